// File: doc/BRIEF.md
# Terrain Hazard Controller

This block tracks the terrain under the player token in a lane-crossing game and decides, once per video frame, whether the token is safe, has died or has won. Upstream logic samples the pixels under the token footprint during the frame. It reduces them to a few flags: whether the whole background there is green, black or blue, whether any object pixel is non-black or brown, and whether every object pixel is black. The flags arrive with the token's lane index and a per-frame evaluation strobe, usually taken from vertical sync.

The controller has five states: grass, road, river, dead and win. Which object colour is lethal depends on the terrain state. On the road, anything that is not black under the token kills it. On the river, the token dies when no log is under it. After a death or a win, the controller holds that outcome for a fixed number of clock cycles. It then pulses a game-reset request and returns to grass. While the token is on the river and a log is under it, an on-log flag is driven combinationally from the current state and the brown-object input.

Top module: `hazard_fsm`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the state is grass and dead_o, win_o, on_log_o and reset_req_o are all 0.
- R2: Terrain state changes only on a clock edge where frame_tick_i is 1. Colour inputs presented without a tick never produce a death or a win.
- R3: On a tick with bg_all_green_i=1 and lane_i not 0, the next state is grass. Grass never kills and never drives on_log_o.
- R4: On a tick with bg_all_black_i=1, the next state is road. A tick while in road with obj_any_nonblack_i=1 moves to dead, and dead_o is 1 from the following cycle.
- R5: On a tick with bg_all_blue_i=1, the next state is river. In river, on_log_o equals obj_any_brown_i in the same cycle, with no register between them.
- R6: A tick while in river with obj_all_black_i=1 moves to dead.
- R7: A tick with lane_i equal to 0 and bg_all_green_i=1 moves to win, and win_o is 1 from the following cycle.
- R8: The death checks of R4 and R6 take priority over win and over every terrain reclassification on the same tick.
- R9: A tick on which none of the three background-uniform flags is set leaves the terrain state unchanged.
- R10: dead_o or win_o stays 1 for exactly HOLD_CYCLES cycles. In the next cycle, reset_req_o is 1 for one cycle with dead_o and win_o at 0. The state is then grass.
- R11: While dead or win is held, ticks and colour inputs are ignored. The held outcome neither changes nor ends early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | One-cycle strobe per frame; the summary flags are evaluated on it |
| lane_i | input | LANE_W | Lane index of the token; 0 is the goal lane |
| bg_all_green_i | input | 1 | Every background pixel under the token is green |
| bg_all_black_i | input | 1 | Every background pixel under the token is black |
| bg_all_blue_i | input | 1 | Every background pixel under the token is blue |
| obj_any_nonblack_i | input | 1 | At least one object pixel under the token is not black |
| obj_any_brown_i | input | 1 | At least one object pixel under the token is brown (log) |
| obj_all_black_i | input | 1 | Every object pixel under the token is black |
| dead_o | output | 1 | Token is dead and the hold is running |
| win_o | output | 1 | Token has won and the hold is running |
| on_log_o | output | 1 | Token rides a log on the river |
| reset_req_o | output | 1 | One-cycle game-reset request at the end of a hold |

## Verification
The bench presents lethal colours without a strobe. A design that evaluates every cycle would kill the token at once. It sends a single strobe that qualifies for both death and win. A design that tests win first would report a win for a token hit on its way onto the goal row. It counts the hold length cycle by cycle and strobes winning conditions in the middle of a death hold. An off-by-one counter, or a hold that ignores neither input, shows up as a wrong count or as a stray win_o. After each hold it probes the terrain state with a mixed-background strobe and a non-black object. A design that returns to road instead of grass then kills the token.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [2:0] {
    ST_GRASS = 3'd0,
    ST_ROAD  = 3'd1,
    ST_RIVER = 3'd2,
    ST_DEAD  = 3'd3,
    ST_WIN   = 3'd4
  } terrain_e;

  function automatic logic is_hold(terrain_e s);
    return (s == ST_DEAD) || (s == ST_WIN);
  endfunction
endpackage

// File: rtl/hazard_next.sv
module hazard_next
  import hazard_pkg::*;
#(
  parameter int LANE_W = 4
) (
  input  terrain_e          state_i,
  input  logic              tick_i,
  input  logic              hold_done_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              bg_all_green_i,
  input  logic              bg_all_black_i,
  input  logic              bg_all_blue_i,
  input  logic              obj_any_nonblack_i,
  input  logic              obj_all_black_i,
  output terrain_e          state_o
);
  logic hit_road, sunk_river, at_goal;

  assign hit_road   = (state_i == ST_ROAD)  && obj_any_nonblack_i;
  assign sunk_river = (state_i == ST_RIVER) && obj_all_black_i;
  assign at_goal    = (lane_i == '0) && bg_all_green_i;

  always_comb begin
    state_o = state_i;
    if (is_hold(state_i)) begin
      // hold ignores frame inputs; only the timer ends it
      if (hold_done_i) state_o = ST_GRASS;
    end else if (tick_i) begin
      if (hit_road || sunk_river) state_o = ST_DEAD;
      else if (at_goal)           state_o = ST_WIN;
      else if (bg_all_green_i)    state_o = ST_GRASS;
      else if (bg_all_black_i)    state_o = ST_ROAD;
      else if (bg_all_blue_i)     state_o = ST_RIVER;
    end
  end
endmodule

// File: rtl/hazard_hold_timer.sv
module hazard_hold_timer #(
  parameter int HOLD_CYCLES = 75_000_000,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic running_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // clears whenever the hold state is left, so each entry starts at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!active_i)     cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign running_o = active_i && (cnt_q != LIMIT);
  assign done_o    = active_i && (cnt_q == LIMIT);
endmodule

// File: rtl/hazard_fsm.sv
module hazard_fsm
  import hazard_pkg::*;
#(
  parameter int LANE_W      = 4,
  parameter int HOLD_CYCLES = 75_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              bg_all_green_i,
  input  logic              bg_all_black_i,
  input  logic              bg_all_blue_i,
  input  logic              obj_any_nonblack_i,
  input  logic              obj_any_brown_i,
  input  logic              obj_all_black_i,
  output logic              dead_o,
  output logic              win_o,
  output logic              on_log_o,
  output logic              reset_req_o
);
  terrain_e state_q, state_d;
  logic     hold_run, hold_done;

  hazard_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (is_hold(state_q)),
    .running_o(hold_run),
    .done_o   (hold_done)
  );

  hazard_next #(.LANE_W(LANE_W)) u_next (
    .state_i           (state_q),
    .tick_i            (frame_tick_i),
    .hold_done_i       (hold_done),
    .lane_i            (lane_i),
    .bg_all_green_i    (bg_all_green_i),
    .bg_all_black_i    (bg_all_black_i),
    .bg_all_blue_i     (bg_all_blue_i),
    .obj_any_nonblack_i(obj_any_nonblack_i),
    .obj_all_black_i   (obj_all_black_i),
    .state_o           (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_GRASS;
    else         state_q <= state_d;
  end

  assign dead_o      = (state_q == ST_DEAD) && hold_run;
  assign win_o       = (state_q == ST_WIN)  && hold_run;
  assign reset_req_o = hold_done;
  assign on_log_o    = (state_q == ST_RIVER) && obj_any_brown_i;
endmodule

// File: rtl/hazard_fsm_chk.sv
module hazard_fsm_chk #(
  parameter int HOLD_CYCLES = 75_000_000,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_tick_i,
  input logic obj_any_brown_i,
  input logic dead_o,
  input logic win_o,
  input logic on_log_o,
  input logic reset_req_o
);
  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               held_q <= '0;
    else if (dead_o || win_o)  held_q <= held_q + 1'b1;
    else                       held_q <= '0;
  end

  // R10
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q <= CNT_W'(HOLD_CYCLES));

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o && !dead_o && !win_o);

  // R10
  req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> !dead_o && !win_o);

  // R5
  log_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_log_o |-> obj_any_brown_i && !dead_o && !win_o);

  // R2
  no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_tick_i && !dead_o && !win_o && !reset_req_o) |=> (!dead_o && !win_o));

  // R11
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dead_o && win_o));
endmodule

bind hazard_fsm hazard_fsm_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frame_tick_i   (frame_tick_i),
  .obj_any_brown_i(obj_any_brown_i),
  .dead_o         (dead_o),
  .win_o          (win_o),
  .on_log_o       (on_log_o),
  .reset_req_o    (reset_req_o)
);

// File: tb/hazard_fsm_tb.sv
module hazard_fsm_tb_top;
  localparam int LANE_W = 4;
  localparam int HOLD   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [LANE_W-1:0] lane = 4'd5;
  logic g = 1'b0, bk = 1'b0, bl = 1'b0;
  logic nb = 1'b0, br = 1'b0, ab = 1'b0;
  logic dead, win, on_log, rreq;
  int   n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  hazard_fsm #(.LANE_W(LANE_W), .HOLD_CYCLES(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick), .lane_i(lane),
    .bg_all_green_i(g), .bg_all_black_i(bk), .bg_all_blue_i(bl),
    .obj_any_nonblack_i(nb), .obj_any_brown_i(br), .obj_all_black_i(ab),
    .dead_o(dead), .win_o(win), .on_log_o(on_log), .reset_req_o(rreq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [2:0] bgv, input logic [2:0] objv, input int ln);
    {g, bk, bl} = bgv;
    {nb, br, ab} = objv;
    lane = LANE_W'(ln);
  endtask

  // one-cycle strobe; returns at the negedge after the updating edge
  task automatic strobe(input logic [2:0] bgv, input logic [2:0] objv, input int ln);
    @(negedge clk);
    set_in(bgv, objv, ln);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // entered from the first negedge with the outcome visible
  task automatic hold_run(input string req, input logic want_win, input logic poke);
    int n = 0;
    int seen_other = 0;
    while ((want_win ? win : dead) && n < HOLD + 5) begin
      n++;
      if (want_win ? dead : win) seen_other++;
      if (poke && n == 3) begin
        set_in(3'b100, 3'b100, 0);
        tick = 1'b1;
      end else tick = 1'b0;
      @(negedge clk);
    end
    tick = 1'b0;
    check(n == HOLD, req, n, HOLD);
    check(seen_other == 0, "R11", seen_other, 0);
    check(rreq && !dead && !win, "R10", {rreq, dead, win}, 3'b100);
    @(negedge clk);
    check(!rreq && !dead && !win, "R10", {rreq, dead, win}, 0);
  endtask

  // mixed background + non-black object: kills only if state is road
  task automatic probe_not_road(input string req);
    strobe(3'b000, 3'b100, 4);
    check(!dead, req, dead, 0);
    set_in(3'b000, 3'b000, 4);
  endtask

  task automatic t_reset;
    check({dead, win, on_log, rreq} == 0, "R1", {dead, win, on_log, rreq}, 0);
    @(negedge clk); rst_n = 1'b1;
    check({dead, win, on_log, rreq} == 0, "R1", {dead, win, on_log, rreq}, 0);
    probe_not_road("R1");
  endtask

  task automatic t_no_tick;
    strobe(3'b010, 3'b001, 4);                  // enter road cleanly
    set_in(3'b010, 3'b100, 4);
    repeat (5) @(negedge clk);
    check(!dead, "R2", dead, 0);
    set_in(3'b100, 3'b000, 0);
    repeat (3) @(negedge clk);
    check(!win, "R2", win, 0);
  endtask

  task automatic t_road_death;
    strobe(3'b010, 3'b001, 4);
    check(!dead, "R4", dead, 0);
    strobe(3'b010, 3'b100, 4);
    check(dead, "R4", dead, 1);
    hold_run("R10", 1'b0, 1'b1);
    probe_not_road("R10");
  endtask

  task automatic t_mixed_keeps;
    strobe(3'b010, 3'b001, 4);
    strobe(3'b000, 3'b001, 4);                  // mixed, clean: stay road
    strobe(3'b000, 3'b100, 4);                  // still road: dies
    check(dead, "R9", dead, 1);
    hold_run("R10", 1'b0, 1'b0);
  endtask

  task automatic t_river;
    strobe(3'b001, 3'b010, 4);
    check(on_log, "R5", on_log, 1);
    @(negedge clk); br = 1'b0;
    #1 check(!on_log, "R5", on_log, 0);
    br = 1'b1;
    #1 check(on_log, "R5", on_log, 1);
    strobe(3'b001, 3'b001, 4);
    check(dead && !on_log, "R6", {dead, on_log}, 2'b10);
    hold_run("R10", 1'b0, 1'b0);
  endtask

  task automatic t_grass;
    strobe(3'b010, 3'b001, 3);
    strobe(3'b100, 3'b110, 3);                  // brown present, no death on road? nb set -> die
    check(dead, "R8", dead, 1);                 // road death wins over green reclass
    hold_run("R10", 1'b0, 1'b0);
    strobe(3'b010, 3'b001, 3);
    strobe(3'b100, 3'b001, 3);
    check(!dead && !win, "R3", {dead, win}, 0);
    probe_not_road("R3");
    strobe(3'b100, 3'b010, 3);
    check(!on_log, "R3", on_log, 0);
  endtask

  task automatic t_win;
    strobe(3'b100, 3'b001, 0);
    check(win && !dead, "R7", {win, dead}, 2'b10);
    hold_run("R10", 1'b1, 1'b0);
    probe_not_road("R10");
  endtask

  task automatic t_priority;
    strobe(3'b010, 3'b001, 1);
    strobe(3'b100, 3'b100, 0);                  // lethal object on goal row
    check(dead && !win, "R8", {dead, win}, 2'b10);
    hold_run("R10", 1'b0, 1'b0);
    strobe(3'b001, 3'b010, 1);
    strobe(3'b100, 3'b001, 0);                  // no log, over goal
    check(dead && !win, "R8", {dead, win}, 2'b10);
    hold_run("R10", 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_tick();
    t_road_death();
    t_mixed_keeps();
    t_river();
    t_grass();
    t_win();
    t_priority();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule